// File: doc/BRIEF.md
# Sensor Configuration Scan Controller

This block is the slow-control port of a pixel sensor: an IEEE 1149.1 test access port whose data registers carry the bias codes, a per-column disable mask and two readout-mode bytes. A host moves the port through its sixteen-state controller with TMS on the rising edge of TCK. It loads a 5-bit instruction that selects one data register. It then shifts new contents in through TDI while the old contents leave on TDO, least significant bit first.

Every writable data register has two stages. The scan stage captures the live value and shifts. The update stage holds the value the sensor uses and changes only in Update-DR. The update stages and four decoded mode bits come out as parallel ports. A read-only identification register and a 1-bit bypass register complete the set. Any instruction code without a register of its own selects bypass.

Top module: `jcb_top`

## Requirements
- R1: While `trst_n` is low, the column mask, the bias word, both mode bytes, the boundary word, `tdo` and `tdo_en` are all zero. Leaving reset puts the controller in Test-Logic-Reset with instruction 0x0E loaded, so the first data scan returns 0xFFFF8001.
- R2: In Capture-IR the instruction scan stage loads the current instruction with bit 0 forced to 1 and bit 1 forced to 0. Bits 4:2 keep the instruction.
- R3: Instruction codes select registers as follows. 0x0E selects the 32-bit identification. 0x0F selects the 88-bit bias word. 0x10 selects the 256-bit column mask. 0x1E selects mode byte 0 and 0x1D selects mode byte 1. 0x01, 0x03 and 0x05 select the 9-bit boundary word.
- R4: Codes 0x02, 0x04 and 0x1F select the 1-bit bypass register, as do the reserved codes 0x11 to 0x1C and every other unlisted code. Bypass captures 0 and delays TDI by one bit. A scan through it changes no parallel output.
- R5: The identification register is read-only. Shifting data into it leaves its next readout at 0xFFFF8001.
- R6: A scan of a writable register returns its previous contents on TDO, least significant bit first.
- R7: An update stage loads only in Update-DR, and only when its own instruction is current. All other parallel outputs keep their values.
- R8: `tdo_en` is high only in Shift-IR and Shift-DR. `tdo` and `tdo_en` change on the falling edge of TCK only.
- R9: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset, which reloads instruction 0x0E. The configuration registers keep their values.
- R10: The decoded mode outputs come from mode byte 0: bit 0 drives `test_mode`, bit 3 drives `gain_hi`, bit 4 drives `marker_sel` and bit 5 drives `lvds_off`. In the bias word, DAC k occupies bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Scan clock |
| tms | input | 1 | Mode select, sampled on TCK rising edge |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous reset, active low |
| tdo | output | 1 | Serial data out, changes on TCK falling edge |
| tdo_en | output | 1 | High while a shift state drives `tdo` |
| bscan_q | output | BSC_W (9) | Boundary word update stage |
| bias_q | output | DAC_N*DAC_W (88) | Eleven DAC codes, DAC0 in the low byte |
| colmask_q | output | COL_N (256) | Column disable mask, 1 disables |
| mode0_q | output | MODE_W (8) | Readout mode byte 0 |
| mode1_q | output | MODE_W (8) | Readout mode byte 1 |
| test_mode | output | 1 | Test-level injection enable |
| gain_hi | output | 1 | Higher output gain select |
| marker_sel | output | 1 | Marker pad source select |
| lvds_off | output | 1 | Readout clock receiver disable |

## Verification
The bench builds the block at its default parameters: eleven 8-bit DACs, a 256-column mask and 8-bit mode bytes. At these sizes every register reaches its full width. The bench can therefore walk a 256-bit pattern through the column mask and compare the whole bias word, and both ends of each register are checked. The fixed 5-bit instruction width lets a run of scans visit every listed code, a reserved code and an unlisted code in one table.

// File: rtl/jcb_pkg.sv
package jcb_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_st_t;

   typedef enum logic [2:0] {
      DR_BYP, DR_BSC, DR_IDC, DR_BIAS, DR_COL, DR_M0, DR_M1
   } dr_sel_t;

   localparam logic [4:0] OP_EXTEST  = 5'h01;
   localparam logic [4:0] OP_HIGHZ   = 5'h02;
   localparam logic [4:0] OP_INTEST  = 5'h03;
   localparam logic [4:0] OP_CLAMP   = 5'h04;
   localparam logic [4:0] OP_SAMPLE  = 5'h05;
   localparam logic [4:0] OP_IDCODE  = 5'h0E;
   localparam logic [4:0] OP_BIAS    = 5'h0F;
   localparam logic [4:0] OP_COLMASK = 5'h10;
   localparam logic [4:0] OP_MODE1   = 5'h1D;
   localparam logic [4:0] OP_MODE0   = 5'h1E;
   localparam logic [4:0] OP_BYPASS  = 5'h1F;

   function automatic dr_sel_t op_decode(input logic [4:0] op);
      case (op)
         OP_EXTEST, OP_INTEST, OP_SAMPLE: op_decode = DR_BSC;
         OP_IDCODE:                       op_decode = DR_IDC;
         OP_BIAS:                         op_decode = DR_BIAS;
         OP_COLMASK:                      op_decode = DR_COL;
         OP_MODE0:                        op_decode = DR_M0;
         OP_MODE1:                        op_decode = DR_M1;
         default:                         op_decode = DR_BYP;
      endcase
   endfunction

endpackage

// File: rtl/jcb_tap_fsm.sv
module jcb_tap_fsm
   import jcb_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_t st
);

   tap_st_t nx;

   always_comb begin
      case (st)
         ST_TLR:    nx = tms ? ST_TLR    : ST_IDLE;
         ST_IDLE:   nx = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nx = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nx = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nx = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nx = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nx = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nx = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nx = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nx = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nx = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nx = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nx = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nx = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nx = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nx = tms ? ST_SEL_DR : ST_IDLE;
         default:   nx = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= ST_TLR;
      else         st <= nx;
   end

endmodule

// File: rtl/jcb_scan_reg.sv
module jcb_scan_reg #(
   parameter int W = 8
) (
   input  logic         tck,
   input  logic         trst_n,
   input  logic         sel,
   input  logic         cap,
   input  logic         shf,
   input  logic         upd,
   input  logic         tdi,
   output logic         so,
   output logic [W-1:0] q
);

   logic [W-1:0] sr;
   logic [W-1:0] sr_nx;

   generate
      if (W == 1) begin : g_one
         assign sr_nx = tdi;
      end else begin : g_multi
         assign sr_nx = {tdi, sr[W-1:1]};
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         sr <= '0;
      else if (sel && cap) sr <= q;
      else if (sel && shf) sr <= sr_nx;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         q <= '0;
      else if (sel && upd) q <= sr;
   end

   assign so = sr[0];

endmodule

// File: rtl/jcb_top.sv
module jcb_top
   import jcb_pkg::*;
#(
   parameter int          IR_W   = 5,
   parameter int          BSC_W  = 9,
   parameter int          DAC_N  = 11,
   parameter int          DAC_W  = 8,
   parameter int          COL_N  = 256,
   parameter int          MODE_W = 8,
   parameter logic [31:0] ID_VAL = 32'hFFFF_8001
) (
   input  logic                     tck,
   input  logic                     tms,
   input  logic                     tdi,
   input  logic                     trst_n,
   output logic                     tdo,
   output logic                     tdo_en,
   output logic [BSC_W-1:0]         bscan_q,
   output logic [DAC_N*DAC_W-1:0]   bias_q,
   output logic [COL_N-1:0]         colmask_q,
   output logic [MODE_W-1:0]        mode0_q,
   output logic [MODE_W-1:0]        mode1_q,
   output logic                     test_mode,
   output logic                     gain_hi,
   output logic                     marker_sel,
   output logic                     lvds_off
);

   localparam int BIAS_W = DAC_N * DAC_W;
   localparam int ID_W   = 32;

   generate
      if (IR_W != 5) begin : g_bad_ir
         $error("jcb_top: the instruction map needs IR_W of 5");
      end
      if (MODE_W < 6) begin : g_bad_mode
         $error("jcb_top: MODE_W must hold the decoded mode bits");
      end
      if (BSC_W < 1 || COL_N < 1 || BIAS_W < 1) begin : g_bad_size
         $error("jcb_top: register widths must be positive");
      end
   endgenerate

   tap_st_t st;
   jcb_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

   // instruction register: scan stage and current instruction
   logic [IR_W-1:0] ir_sr, ir_q;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
         ir_q  <= OP_IDCODE;
      end else begin
         case (st)
            ST_TLR:    ir_q  <= OP_IDCODE;
            ST_CAP_IR: ir_sr <= {ir_q[IR_W-1:2], 2'b01};
            ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            ST_UPD_IR: ir_q  <= ir_sr;
            default:   ;
         endcase
      end
   end

   dr_sel_t dsel;
   assign dsel = op_decode(ir_q);

   logic cap, shf, upd;
   assign cap = (st == ST_CAP_DR);
   assign shf = (st == ST_SH_DR);
   assign upd = (st == ST_UPD_DR);

   // bypass: captures zero
   logic byp;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  byp <= 1'b0;
      else if (dsel == DR_BYP && cap) byp <= 1'b0;
      else if (dsel == DR_BYP && shf) byp <= tdi;
   end

   // identification: read-only, no update stage
   logic [ID_W-1:0] id_sr;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  id_sr <= '0;
      else if (dsel == DR_IDC && cap) id_sr <= ID_VAL;
      else if (dsel == DR_IDC && shf) id_sr <= {tdi, id_sr[ID_W-1:1]};
   end

   logic so_bsc, so_bias, so_col, so_m0, so_m1;

   jcb_scan_reg #(.W(BSC_W)) u_bsc (
      .tck(tck), .trst_n(trst_n), .sel(dsel == DR_BSC), .cap(cap), .shf(shf),
      .upd(upd), .tdi(tdi), .so(so_bsc), .q(bscan_q));
   jcb_scan_reg #(.W(BIAS_W)) u_bias (
      .tck(tck), .trst_n(trst_n), .sel(dsel == DR_BIAS), .cap(cap), .shf(shf),
      .upd(upd), .tdi(tdi), .so(so_bias), .q(bias_q));
   jcb_scan_reg #(.W(COL_N)) u_col (
      .tck(tck), .trst_n(trst_n), .sel(dsel == DR_COL), .cap(cap), .shf(shf),
      .upd(upd), .tdi(tdi), .so(so_col), .q(colmask_q));
   jcb_scan_reg #(.W(MODE_W)) u_m0 (
      .tck(tck), .trst_n(trst_n), .sel(dsel == DR_M0), .cap(cap), .shf(shf),
      .upd(upd), .tdi(tdi), .so(so_m0), .q(mode0_q));
   jcb_scan_reg #(.W(MODE_W)) u_m1 (
      .tck(tck), .trst_n(trst_n), .sel(dsel == DR_M1), .cap(cap), .shf(shf),
      .upd(upd), .tdi(tdi), .so(so_m1), .q(mode1_q));

   logic dr_so;
   always_comb begin
      case (dsel)
         DR_BSC:  dr_so = so_bsc;
         DR_IDC:  dr_so = id_sr[0];
         DR_BIAS: dr_so = so_bias;
         DR_COL:  dr_so = so_col;
         DR_M0:   dr_so = so_m0;
         DR_M1:   dr_so = so_m1;
         default: dr_so = byp;
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= (st == ST_SH_DR) ? dr_so : (st == ST_SH_IR) ? ir_sr[0] : 1'b0;
         tdo_en <= (st == ST_SH_DR) || (st == ST_SH_IR);
      end
   end

   assign test_mode  = mode0_q[0];
   assign gain_hi    = mode0_q[3];
   assign marker_sel = mode0_q[4];
   assign lvds_off   = mode0_q[5];

endmodule

// File: rtl/jcb_chk.sv
module jcb_chk
   import jcb_pkg::*;
#(
   parameter int BIAS_W = 88,
   parameter int COL_N  = 256,
   parameter int MODE_W = 8
) (
   input logic              tck,
   input logic              trst_n,
   input logic              tms,
   input logic              tdo_en,
   input tap_st_t           st,
   input logic [4:0]        ir_q,
   input logic [BIAS_W-1:0] bias_q,
   input logic [COL_N-1:0]  colmask_q,
   input logic [MODE_W-1:0] mode1_q
);

   logic [2:0] ones;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)      ones <= 3'd0;
      else if (!tms)    ones <= 3'd0;
      else if (ones < 5) ones <= ones + 3'd1;
   end

   always_ff @(posedge tck) begin
      if (trst_n && ones >= 3'd5)
         AST_FIVE_HIGH_TLR: assert (st == ST_TLR); // R9
   end

   AST_TLR_LOADS_ID: assert property (@(posedge tck) disable iff (!trst_n)
      (st == ST_TLR) |=> (ir_q == OP_IDCODE)); // R9

   AST_BIAS_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      (st != ST_UPD_DR) |=> $stable(bias_q)); // R7

   AST_COL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      !(st == ST_UPD_DR && ir_q == OP_COLMASK) |=> $stable(colmask_q)); // R7

   AST_MODE1_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
      !(st == ST_UPD_DR && ir_q == OP_MODE1) |=> $stable(mode1_q)); // R7

   AST_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
      !(st == ST_SH_DR || st == ST_SH_IR) |-> !tdo_en); // R8

endmodule

bind jcb_top jcb_chk #(.BIAS_W(DAC_N*DAC_W), .COL_N(COL_N), .MODE_W(MODE_W)) u_chk (
   .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en), .st(st),
   .ir_q(ir_q), .bias_q(bias_q), .colmask_q(colmask_q), .mode1_q(mode1_q));

// File: tb/jcb_top_test.sv
`timescale 1ns/1ps
module jcb_top_test;

   logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
   logic tdo, tdo_en, test_mode, gain_hi, marker_sel, lvds_off;
   logic [8:0]   bscan_q;
   logic [87:0]  bias_q;
   logic [255:0] colmask_q;
   logic [7:0]   mode0_q, mode1_q;

   always #2 tck = ~tck;

   jcb_top uut (.tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
      .tdo_en(tdo_en), .bscan_q(bscan_q), .bias_q(bias_q), .colmask_q(colmask_q),
      .mode0_q(mode0_q), .mode1_q(mode1_q), .test_mode(test_mode), .gain_hi(gain_hi),
      .marker_sel(marker_sel), .lvds_off(lvds_off));

   localparam logic [31:0] IDV = 32'hFFFF_8001;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 0;
   bit  edge_ok = 1, en_ok = 1;

   task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                      input logic [255:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d, output logic o);
      tms = m; tdi = d; o = tdo;
      @(posedge tck); #0.5;
      if (tdo !== o) edge_ok = 0;
      @(negedge tck); #1;
   endtask

   task automatic ir_scan(input logic [4:0] op, output logic [4:0] cap);
      logic o;
      step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) begin
         if (tdo_en !== 1'b1) en_ok = 0;
         step(i == 4, op[i], o); cap[i] = o;
      end
      step(1, 0, o); step(0, 0, o);
      if (tdo_en !== 1'b0) en_ok = 0;
   endtask

   task automatic dr_scan(input logic [255:0] din, input int n, output logic [255:0] dout);
      logic o;
      dout = '0;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < n; i++) begin
         if (tdo_en !== 1'b1) en_ok = 0;
         step(i == n - 1, din[i], o); dout[i] = o;
      end
      step(1, 0, o); step(0, 0, o);
      if (tdo_en !== 1'b0) en_ok = 0;
   endtask

   typedef struct packed {
      logic [4:0]   op;
      logic [8:0]   n;
      logic [255:0] d;
   } vec_t;

   localparam vec_t VECS [18] = '{
      '{5'h0E, 9'd32,  256'h0},
      '{5'h0F, 9'd88,  256'h01_23_45_67_89_AB_CD_EF_FE_DC_BA},
      '{5'h0F, 9'd88,  256'h80_00_00_00_00_00_00_00_00_00_01},
      '{5'h10, 9'd256, {8{32'hDEAD_BEEF}}},
      '{5'h10, 9'd256, {4{64'h8000_0000_0000_0001}}},
      '{5'h1E, 9'd8,   256'h39},
      '{5'h1D, 9'd8,   256'hC4},
      '{5'h01, 9'd9,   256'h1A5},
      '{5'h05, 9'd9,   256'h05A},
      '{5'h03, 9'd9,   256'h0},
      '{5'h15, 9'd8,   256'hB3},
      '{5'h02, 9'd8,   256'h6D},
      '{5'h04, 9'd8,   256'hF0},
      '{5'h1F, 9'd8,   256'h81},
      '{5'h00, 9'd8,   256'h5C},
      '{5'h0E, 9'd32,  256'h1234_5678},
      '{5'h0E, 9'd32,  256'h0},
      '{5'h1E, 9'd8,   256'h00}
   };

   logic [87:0]  bias_m = '0;
   logic [255:0] col_m  = '0;
   logic [7:0]   m0_m = '0, m1_m = '0;
   logic [8:0]   bsc_m = '0;
   logic [4:0]   ir_m = 5'h0E;

   task automatic check_par(input string tag);
      chk({bias_q, colmask_q, mode0_q, mode1_q, bscan_q} ===
          {bias_m, col_m, m0_m, m1_m, bsc_m}, tag,
          {bias_q[15:0], mode0_q, mode1_q, 7'd0, bscan_q},
          {bias_m[15:0], m0_m, m1_m, 7'd0, bsc_m});
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [255:0] dout, exp;
      logic [4:0]   cap;
      logic         o;
      // R1: reset state
      #7;
      chk({bias_q, colmask_q, mode0_q, mode1_q, bscan_q, tdo, tdo_en} === '0, "R1 reset outputs",
          {mode0_q, bscan_q, tdo, tdo_en}, 0);
      @(negedge tck); #1; trst_n = 1'b1;
      step(0, 0, o);
      dr_scan(0, 32, dout);
      chk(dout[31:0] === IDV, "R1 id after reset", dout, IDV);

      // table walk: R2 R3 R4 R5 R6 R7
      foreach (VECS[k]) begin
         ir_scan(VECS[k].op, cap);
         chk(cap === {ir_m[4:2], 2'b01}, "R2 ir capture", cap, {ir_m[4:2], 2'b01});
         ir_m = VECS[k].op;
         dr_scan(VECS[k].d, VECS[k].n, dout);
         case (VECS[k].op)
            5'h0E: exp = IDV;
            5'h0F: exp = bias_m;
            5'h10: exp = col_m;
            5'h1E: exp = m0_m;
            5'h1D: exp = m1_m;
            5'h01, 5'h03, 5'h05: exp = bsc_m;
            default: exp = {VECS[k].d[254:0], 1'b0} & 256'hFF;
         endcase
         case (VECS[k].op)
            5'h0E: chk(dout === exp, "R5 id read-only", dout, exp);
            5'h0F, 5'h10, 5'h1E, 5'h1D, 5'h01, 5'h03, 5'h05:
                   chk(dout === exp, "R6 previous contents", dout, exp);
            default: chk(dout === exp, "R4 bypass delay", dout, exp);
         endcase
         case (VECS[k].op)
            5'h0F: bias_m = VECS[k].d[87:0];
            5'h10: col_m  = VECS[k].d;
            5'h1E: m0_m   = VECS[k].d[7:0];
            5'h1D: m1_m   = VECS[k].d[7:0];
            5'h01, 5'h03, 5'h05: bsc_m = VECS[k].d[8:0];
            default: ;
         endcase
         check_par("R3 R7 parallel outputs");
         if (k == 5)
            chk({test_mode, gain_hi, marker_sel, lvds_off} === 4'b1111, "R10 mode 0x39",
                {test_mode, gain_hi, marker_sel, lvds_off}, 4'b1111);
      end

      // R10: bias byte placement and further mode decodes
      chk(bias_q[87:80] === 8'h80 && bias_q[7:0] === 8'h01, "R10 DAC10/DAC0 bytes",
          bias_q, 88'h80_00_00_00_00_00_00_00_00_00_01);
      ir_scan(5'h1E, cap); ir_m = 5'h1E;
      dr_scan(256'h21, 8, dout);
      chk({test_mode, gain_hi, marker_sel, lvds_off} === 4'b1001, "R10 mode 0x21",
          {test_mode, gain_hi, marker_sel, lvds_off}, 4'b1001);
      dr_scan(256'h08, 8, dout);
      chk({test_mode, gain_hi, marker_sel, lvds_off} === 4'b0100, "R10 mode 0x08",
          {test_mode, gain_hi, marker_sel, lvds_off}, 4'b0100);
      m0_m = 8'h08;

      // R8: enable window and falling-edge timing
      chk(en_ok, "R8 tdo_en only in shift", en_ok, 1);
      chk(edge_ok, "R8 tdo changes on falling edge", edge_ok, 1);

      // R9: five TMS-high edges from Shift-DR with bypass selected
      ir_scan(5'h1F, cap); ir_m = 5'h1F;
      step(1, 0, o); step(0, 0, o); step(0, 0, o);
      for (int i = 0; i < 5; i++) step(1, 1, o);
      step(0, 0, o);
      ir_m = 5'h0E;
      dr_scan(0, 32, dout);
      chk(dout[31:0] === IDV, "R9 id after five TMS high", dout, IDV);
      check_par("R9 config kept");

      // R1: asynchronous reset mid-run
      tms = 1'b0; trst_n = 1'b0; #1;
      chk({bias_q, colmask_q, mode0_q, mode1_q, bscan_q, tdo_en} === '0, "R1 async clear",
          {mode0_q, mode1_q, bscan_q}, 0);
      @(negedge tck); #1; trst_n = 1'b1;
      step(0, 0, o);
      ir_scan(5'h1F, cap);
      chk(cap === 5'b01101, "R1 R2 capture after reset", cap, 5'b01101);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule